// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block takes a floating-point operand that has already been unpacked into class, sign, unbiased exponent and mantissa fields, and turns it into a signed two's-complement integer. It always discards the fraction, so the result moves toward zero. No rounding increment is ever applied and no rounding-mode input exists. Two flags come with each result. One reports that nonzero bits were dropped, and the other reports that the operand cannot be represented. Out-of-range operands and non-numbers saturate to a limit that depends on the sign.

The mantissa holds an explicit leading one in its top bit, which has weight 2^exponent. The lower bits continue the fraction, down to the guard and round positions. A separate sticky bit summarises any bits below those. An operand is accepted with a one-cycle valid strobe, and the result appears, registered, one clock later.

Top module: `ftoi_trunc`

## Requirements
- R1: The zero class (`in_class` = 0) produces 0 with both flags clear, whatever the sign, exponent, mantissa or sticky.
- R2: The number class (`in_class` = 1) with an exponent of 32 or more is out of range.
- R3: For the number class with an exponent below 32, the magnitude is the integer part of mantissa × 2^(exponent − (MANT_W − 1)), with the fraction dropped. A negative exponent gives magnitude 0.
- R4: `out_inexact` is set when any nonzero mantissa bit lies below the integer part, or when `in_sticky` is 1. It is clear on every out-of-range result.
- R5: The magnitude is out of range when it is at least 0x80000000 for a positive operand (sign 0), or above 0x80000000 for a negative operand (sign 1).
- R6: An in-range magnitude is output as is when the sign is 0, and negated when the sign is 1.
- R7: An out-of-range result sets `out_invalid` and outputs 0x7FFFFFFF when the sign is 0, or 0x80000000 when the sign is 1.
- R8: Infinity (2), quiet NaN (3), signalling NaN (4) and the unused codes 5 to 7 all take the out-of-range path of R7.
- R9: `out_valid` rises exactly one clock after `in_valid`. While `in_valid` is low, the result and flags hold their last values.
- R10: During reset, `out_valid`, `out_int` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_class | input | 3 | Operand class code |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one in the top bit |
| in_sticky | input | 1 | OR of the bits below the mantissa |
| out_valid | output | 1 | Result strobe |
| out_int | output | INT_W | Integer result |
| out_inexact | output | 1 | Nonzero bits were discarded |
| out_invalid | output | 1 | Operand out of range or not a number |

## Verification
Some properties are checked every cycle. These are the one-cycle valid timing and the holding of outputs while idle. They also include the zero class giving a clean 0, non-numbers always flagging invalid, a saturated value being one of the two limits, the two flags never being set together, and a positive operand never producing a negative integer. The exact magnitude, the placement of the truncation point and the sign-dependent overflow threshold at 0x80000000 cannot be checked that way. The bench's sweep shows them by running every exponent from below zero to beyond the range against several mantissa patterns. Each result is compared with the value computed arithmetically.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } fti_class_e;

endpackage

// File: rtl/fti_align.sv
// Places the integer part of the mantissa into an INT_W-bit field and
// reports discarded bits. Out-of-range exponents are only flagged here.
module fti_align #(
    parameter int MANT_W = 28,
    parameter int EXP_W  = 10,
    parameter int INT_W  = 32
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic                    sticky,
    output logic [INT_W-1:0]        mag,
    output logic                    lost,
    output logic                    big
);
    localparam int W     = MANT_W + 2 * INT_W;
    localparam int POINT = MANT_W - 1 + INT_W;
    localparam int SH_W  = $clog2(INT_W);

    logic [W-1:0]    wide;
    logic [W-1:0]    shifted;
    logic [SH_W-1:0] amt;
    logic            neg;

    always_comb begin
        wide    = {{INT_W{1'b0}}, mant, {INT_W{1'b0}}};
        neg     = exp_in[EXP_W-1];
        big     = !neg && (exp_in >= EXP_W'(INT_W));
        amt     = exp_in[SH_W-1:0];
        shifted = wide << amt;
        if (neg) begin
            mag  = '0;
            lost = (|mant) | sticky;
        end else begin
            mag  = shifted[POINT +: INT_W];
            lost = (|shifted[POINT-1:0]) | sticky;
        end
    end

endmodule

// File: rtl/fti_saturate.sv
// Sign-dependent range check and final sign application.
module fti_saturate #(
    parameter int INT_W = 32
) (
    input  logic [INT_W-1:0] mag,
    input  logic             sign,
    input  logic             force_ovf,
    output logic             ovf,
    output logic [INT_W-1:0] result
);
    localparam logic [INT_W-1:0] LIM_NEG = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] LIM_POS = {1'b0, {(INT_W-1){1'b1}}};

    always_comb begin
        ovf = force_ovf || (mag > LIM_NEG) || ((mag == LIM_NEG) && !sign);
        if (ovf)
            result = sign ? LIM_NEG : LIM_POS;
        else
            result = sign ? (~mag + 1'b1) : mag;
    end

endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc
    import fti_pkg::*;
#(
    parameter int MANT_W = 28,
    parameter int EXP_W  = 10,
    parameter int INT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_sticky,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int,
    output logic                    out_inexact,
    output logic                    out_invalid
);
    typedef struct packed {
        logic             vld;
        logic [INT_W-1:0] val;
        logic             lost;
        logic             inv;
    } res_t;

    res_t st_d, st_q;

    logic [INT_W-1:0] mag_w, res_w;
    logic             lost_w, big_w, ovf_w;
    logic             is_zero, is_num;

    assign is_zero = (in_class == CLS_ZERO);
    assign is_num  = (in_class == CLS_NUM);

    fti_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_align (
        .mant   (in_mant),
        .exp_in (in_exp),
        .sticky (in_sticky),
        .mag    (mag_w),
        .lost   (lost_w),
        .big    (big_w)
    );

    fti_saturate #(.INT_W(INT_W)) u_sat (
        .mag       (mag_w),
        .sign      (in_sign),
        .force_ovf (!is_num || big_w),
        .ovf       (ovf_w),
        .result    (res_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (is_zero) begin
                st_d.val  = '0;
                st_d.lost = 1'b0;
                st_d.inv  = 1'b0;
            end else begin
                st_d.val  = res_w;
                st_d.lost = lost_w && !ovf_w;
                st_d.inv  = ovf_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_int     = st_q.val;
    assign out_inexact = st_q.lost;
    assign out_invalid = st_q.inv;

    // R9: one-cycle latency of the strobe
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_int) && $stable(out_inexact)
                       && $stable(out_invalid)));
    // R1: zero class
    assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == CLS_ZERO) |=>
        (out_int == '0 && !out_inexact && !out_invalid));
    // R8: non-numbers are always invalid
    assert_nonnum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class != CLS_ZERO && in_class != CLS_NUM) |=> out_invalid);
    // R7: a saturated value is one of the two limits
    assert_sat_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |->
        (out_int == {1'b0, {(INT_W-1){1'b1}}} || out_int == {1'b1, {(INT_W-1){1'b0}}}));
    // R4: flags are exclusive
    assert_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
    // R6: a positive operand never yields a negative integer
    assert_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sign) |=> !out_int[INT_W-1]);

endmodule

// File: tb/tb_ftoi_trunc.sv
`timescale 1ns/1ps
module tb_ftoi_trunc;
    localparam int MANT_W = 28;
    localparam int EXP_W  = 10;
    localparam int INT_W  = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [2:0]              in_class = '0;
    logic                    in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [MANT_W-1:0]       in_mant = '0;
    logic                    in_sticky = 1'b0;
    logic                    out_valid;
    logic [INT_W-1:0]        out_int;
    logic                    out_inexact;
    logic                    out_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ftoi_trunc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) dut (
        .clk, .rst_n, .in_valid, .in_class, .in_sign, .in_exp, .in_mant,
        .in_sticky, .out_valid, .out_int, .out_inexact, .out_invalid
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic model(int cls, bit s, int e, longint m, bit st,
                         output logic [31:0] v, output bit lo, output bit iv);
        longint p, mag;
        bit ovf;
        v = 0; lo = 0; iv = 0;
        if (cls == 0) return;
        ovf = 1;
        mag = 0;
        if (cls == 1 && e < 32) begin
            if (e < 0) begin
                mag = 0;
                lo = (m != 0) || st;
            end else begin
                p = m << e;
                mag = p >> (MANT_W - 1);
                lo = ((p & ((64'd1 << (MANT_W - 1)) - 1)) != 0) || st;
            end
            ovf = (mag >= (64'h8000_0000 + longint'(s)));
        end
        if (ovf) begin
            iv = 1; lo = 0;
            v = s ? 32'h8000_0000 : 32'h7FFF_FFFF;
        end else begin
            v = s ? 32'(-mag) : 32'(mag);
        end
    endtask

    task automatic run(int cls, bit s, int e, logic [MANT_W-1:0] m, bit st, string req);
        logic [31:0] ev; bit el, ei; logic [31:0] held;
        model(cls, s, e, longint'(m), st, ev, el, ei);
        @(negedge clk);
        in_valid = 1; in_class = 3'(cls); in_sign = s;
        in_exp = EXP_W'(e); in_mant = m; in_sticky = st;
        @(negedge clk);
        in_valid = 0;
        chk({req, " R9 valid"}, 32'(out_valid), 32'd1);
        chk({req, " value"}, out_int, ev);
        chk({req, " R4 inexact"}, 32'(out_inexact), 32'(el));
        chk({req, " R7 invalid"}, 32'(out_invalid), 32'(ei));
        held = out_int;
        in_mant = ~m; in_sign = ~s;
        @(negedge clk);
        chk("R9 idle valid", 32'(out_valid), 32'd0);
        chk("R9 idle hold", out_int, held);
    endtask

    initial begin
        logic [MANT_W-1:0] pats [6];
        pats[0] = 28'h8000000; pats[1] = 28'hFFFFFFF; pats[2] = 28'hAAAAAAA;
        pats[3] = 28'hC000001; pats[4] = 28'h8000003; pats[5] = 28'h9234567;
        #1;
        // R10: reset state
        repeat (2) @(negedge clk);
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 int", out_int, 0);
        chk("R10 flags", {30'd0, out_inexact, out_invalid}, 0);
        rst_n = 1;
        // R1: zero class with junk fields
        for (int s = 0; s < 2; s++)
            for (int st = 0; st < 2; st++)
                run(0, s[0], 40, 28'hFFFFFFF, st[0], "R1 zero");
        // R2 R3 R5 R6: exponent sweep over mantissa patterns
        for (int p = 0; p < 6; p++)
            for (int e = -3; e <= 34; e++)
                for (int s = 0; s < 2; s++)
                    for (int st = 0; st < 2; st++)
                        run(1, s[0], e, pats[p], st[0], "R3 R5 R6 R2 sweep");
        // R5: exact boundary at 2^31
        run(1, 1'b0, 31, 28'h8000000, 1'b0, "R5 pos boundary");
        run(1, 1'b1, 31, 28'h8000000, 1'b0, "R5 neg boundary");
        run(1, 1'b1, 31, 28'h8000000, 1'b1, "R5 neg boundary sticky");
        // R8: non-number classes
        for (int c = 2; c < 8; c++)
            for (int s = 0; s < 2; s++)
                run(c, s[0], 5, 28'h8000001, 1'b1, "R8 nonnum");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule